// File: doc/BRIEF.md
# Clock Multiplier Configuration Holding Register

This block supplies the multiply and range settings that steer an on-chip clock multiplier. The settings sit in a small bank of holding registers that are not on the scan chain, so scan shifting cannot disturb the multiplier once it is running.

The bank is written through a two-way source selector. One input is a fixed set of safe defaults. The other is the content of the scan-loaded shadow registers, which the block receives on its input ports. A select line from the system clock controller picks the input. Writes are enabled by the level of the bypass control, not by a strobe. While bypass is high the bank tracks the selected source on every clock. When bypass falls the bank keeps its last value. After initialization, a one-cycle reprogram pulse with bypass low copies the shadow settings into the bank, so the frequency can be changed without re-entering bypass.

At power-on the controller must select the default input, because the shadow registers still hold undefined values at that point.

Top module: `clkcfg_hold`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) loads the defaults at that edge: multiply = DEF_MULT (4) and range = DEF_RANGE (2). A DEF_MULT of zero is replaced by 1.
- R2: With bypass_i = 1 and src_sel_i = 0, the outputs show the defaults (4, 2) after the next rising edge.
- R3: With bypass_i = 1 and src_sel_i = 1, the outputs take scan_mult_i and scan_rng_i after the next rising edge, and follow them on every cycle while this holds.
- R4: When bypass_i goes low, the outputs keep the value loaded at the last edge where bypass_i was 1.
- R5: With bypass_i = 0 and reprog_i = 0, changes on scan_mult_i, scan_rng_i or src_sel_i leave the outputs unchanged, including during long runs of scan toggling.
- R6: A reprog_i pulse with bypass_i = 0 loads scan_mult_i and scan_rng_i at the next rising edge, whatever the value of src_sel_i.
- R7: While bypass_i = 1, reprog_i has no effect. The bank follows the selected source, so with src_sel_i = 0 the defaults are loaded even if reprog_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass_i | input | 1 | Bypass level; high enables tracking of the selected source |
| src_sel_i | input | 1 | Source select: 0 = safe defaults, 1 = scan shadow values |
| reprog_i | input | 1 | One-cycle request to copy the shadow values while bypass is low |
| scan_mult_i | input | MULT_W | Multiply value from the scan shadow registers |
| scan_rng_i | input | RANGE_W | Range value from the scan shadow registers |
| mult_o | output | MULT_W | Held multiply setting |
| rng_o | output | RANGE_W | Held range setting |

## Verification
The outputs are the holding registers themselves, so a wrong load decision shows at the ports one edge after the offending cycle. A lost freeze makes the outputs mirror the scan inputs during the next scan toggle. A wrong selector leg shows shadow values where the defaults are expected. A reprogram pulse that is dropped or taken while bypass is high produces the wrong value at the following edge. The bench drives the scan inputs with patterns that differ from the defaults and from the current held value, so each of these faults changes at least one output bit.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int CFG_MULT_W  = 4;
  localparam int CFG_RANGE_W = 3;

  typedef struct packed {
    logic [CFG_MULT_W-1:0]  mult;
    logic [CFG_RANGE_W-1:0] rng;
  } cfg_t;

  // Safe multiply: a zero default would stop the multiplier, so use 1 instead
  function automatic int safe_mult(input int req);
    return (req == 0) ? 1 : req;
  endfunction

  // Value written into the bank when loading is enabled
  function automatic cfg_t load_value(input logic force_shadow, input cfg_t shadow,
                                      input cfg_t selected);
    return force_shadow ? shadow : selected;
  endfunction
endpackage

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl (
  input  logic bypass_i,
  input  logic reprog_i,
  output logic load_en_o,
  output logic force_shadow_o,
  output logic follow_ev_o,
  output logic reprog_ev_o,
  output logic freeze_ev_o
);
  // bypass level tracks the selector; reprogram only counts while bypass is low
  always_comb begin
    follow_ev_o    = bypass_i;
    reprog_ev_o    = !bypass_i && reprog_i;
    freeze_ev_o    = !bypass_i && !reprog_i;
    load_en_o      = follow_ev_o || reprog_ev_o;
    force_shadow_o = reprog_ev_o;
  end
endmodule

// File: rtl/cfg_src_mux.sv
module cfg_src_mux
  import clkcfg_pkg::*;
(
  input  logic sel_i,
  input  cfg_t safe_i,
  input  cfg_t shadow_i,
  output cfg_t out_o
);
  always_comb out_o = sel_i ? shadow_i : safe_i;
endmodule

// File: rtl/cfg_hold_bank.sv
module cfg_hold_bank
  import clkcfg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_en_i,
  input  cfg_t safe_i,
  input  cfg_t din_i,
  output cfg_t q_o
);
  cfg_t q_r;

  always_ff @(posedge clk) begin
    if (rst)            q_r <= safe_i;
    else if (load_en_i) q_r <= din_i;
  end

  assign q_o = q_r;

  // R4: with no load enable the bank keeps its value
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load_en_i |=> $stable(q_r));

  // the bank captures exactly the offered data when enabled
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    load_en_i |=> q_r == $past(din_i));
endmodule

// File: rtl/clkcfg_hold.sv
module clkcfg_hold
  import clkcfg_pkg::*;
#(
  parameter int MULT_W    = CFG_MULT_W,
  parameter int RANGE_W   = CFG_RANGE_W,
  parameter int DEF_MULT  = 4,
  parameter int DEF_RANGE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bypass_i,
  input  logic               src_sel_i,
  input  logic               reprog_i,
  input  logic [MULT_W-1:0]  scan_mult_i,
  input  logic [RANGE_W-1:0] scan_rng_i,
  output logic [MULT_W-1:0]  mult_o,
  output logic [RANGE_W-1:0] rng_o
);
  localparam int SAFE_MULT = safe_mult(DEF_MULT);
  localparam logic [MULT_W-1:0]  SAFE_MULT_V = MULT_W'(SAFE_MULT);
  localparam logic [RANGE_W-1:0] SAFE_RNG_V  = RANGE_W'(DEF_RANGE);

  cfg_t safe_cfg, shadow_cfg, sel_cfg, load_cfg, held_cfg;
  logic load_en, force_shadow, follow_ev, reprog_ev, freeze_ev;

  assign safe_cfg   = '{mult: SAFE_MULT_V, rng: SAFE_RNG_V};
  assign shadow_cfg = '{mult: scan_mult_i, rng: scan_rng_i};

  cfg_load_ctrl u_ctrl (
    .bypass_i       (bypass_i),
    .reprog_i       (reprog_i),
    .load_en_o      (load_en),
    .force_shadow_o (force_shadow),
    .follow_ev_o    (follow_ev),
    .reprog_ev_o    (reprog_ev),
    .freeze_ev_o    (freeze_ev)
  );

  cfg_src_mux u_mux (
    .sel_i    (src_sel_i),
    .safe_i   (safe_cfg),
    .shadow_i (shadow_cfg),
    .out_o    (sel_cfg)
  );

  assign load_cfg = load_value(force_shadow, shadow_cfg, sel_cfg);

  cfg_hold_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .load_en_i (load_en),
    .safe_i    (safe_cfg),
    .din_i     (load_cfg),
    .q_o       (held_cfg)
  );

  assign mult_o = held_cfg.mult;
  assign rng_o  = held_cfg.rng;

  // R2 and R7: in bypass with the default leg selected the defaults load, reprog or not
  assert_safe_leg_R2: assert property (@(posedge clk) disable iff (rst)
    (follow_ev && !src_sel_i) |=> (mult_o == SAFE_MULT_V && rng_o == SAFE_RNG_V));

  // R3: in bypass with the scan leg selected the outputs track the shadow inputs
  assert_scan_leg_R3: assert property (@(posedge clk) disable iff (rst)
    (bypass_i && src_sel_i) |=> (mult_o == $past(scan_mult_i) && rng_o == $past(scan_rng_i)));

  // R5: frozen while bypass is low and no reprogram is requested
  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    freeze_ev |=> ($stable(mult_o) && $stable(rng_o)));

  // R6: reprogram copies the shadow values regardless of the select line
  assert_reprog_R6: assert property (@(posedge clk) disable iff (rst)
    reprog_ev |=> (mult_o == $past(scan_mult_i) && rng_o == $past(scan_rng_i)));
endmodule

// File: tb/test_clkcfg_hold.sv
module test_clkcfg_hold;
  logic clk = 1'b0;
  logic rst, bypass_i, src_sel_i, reprog_i;
  logic [3:0] scan_mult_i;
  logic [2:0] scan_rng_i;
  logic [3:0] mult_o;
  logic [2:0] rng_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  clkcfg_hold i_clkcfg_hold (
    .clk(clk), .rst(rst), .bypass_i(bypass_i), .src_sel_i(src_sel_i),
    .reprog_i(reprog_i), .scan_mult_i(scan_mult_i), .scan_rng_i(scan_rng_i),
    .mult_o(mult_o), .rng_o(rng_o)
  );

  // {req[3:0], rst, bypass, sel, reprog, smult[3:0], srng[2:0], emult[3:0], erng[2:0]}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 4'b1110, 4'd9,  3'd5, 4'd4,  3'd2}, // R1 reset wins over scan leg
    {4'd2, 4'b0100, 4'd9,  3'd5, 4'd4,  3'd2}, // R2 default leg
    {4'd3, 4'b0110, 4'd9,  3'd5, 4'd9,  3'd5}, // R3 scan leg
    {4'd3, 4'b0110, 4'd3,  3'd1, 4'd3,  3'd1}, // R3 follows each cycle
    {4'd4, 4'b0010, 4'd7,  3'd6, 4'd3,  3'd1}, // R4 bypass exit freezes
    {4'd5, 4'b0000, 4'd12, 3'd0, 4'd3,  3'd1}, // R5 select change ignored
    {4'd5, 4'b0010, 4'd1,  3'd7, 4'd3,  3'd1}, // R5 scan change ignored
    {4'd6, 4'b0001, 4'd11, 3'd4, 4'd11, 3'd4}, // R6 reprog with default select
    {4'd5, 4'b0010, 4'd2,  3'd3, 4'd11, 3'd4}, // R5 held after reprog
    {4'd7, 4'b0101, 4'd13, 3'd6, 4'd4,  3'd2}, // R7 reprog ignored in bypass
    {4'd7, 4'b0111, 4'd6,  3'd3, 4'd6,  3'd3}, // R7 bypass scan leg, reprog no effect
    {4'd4, 4'b0010, 4'd8,  3'd1, 4'd6,  3'd3}, // R4 frozen again
    {4'd1, 4'b1000, 4'd8,  3'd1, 4'd4,  3'd2}  // R1 reset while frozen
  };

  task automatic check(input string req, input logic [3:0] em, input logic [2:0] er);
    total++;
    if (mult_o !== em || rng_o !== er) begin
      bad++;
      $display("FAIL %s: mult=%0d rng=%0d expected mult=%0d rng=%0d", req, mult_o, rng_o, em, er);
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bypass_i = 1'b1; src_sel_i = 1'b0; reprog_i = 1'b0;
    scan_mult_i = 4'd15; scan_rng_i = 3'd7;
    repeat (2) @(posedge clk);
    #1 check("R1", 4'd4, 3'd2);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rst, bypass_i, src_sel_i, reprog_i} = VEC[i][17:14];
      scan_mult_i = VEC[i][13:10];
      scan_rng_i  = VEC[i][9:7];
      @(posedge clk);
      #1 check($sformatf("R%0d", VEC[i][21:18]), VEC[i][6:3], VEC[i][2:0]);
    end

    // R3 then R4/R5: load 5,6 in bypass, exit, toggle scan inputs hard
    @(negedge clk);
    rst = 1'b0; bypass_i = 1'b1; src_sel_i = 1'b1; reprog_i = 1'b0;
    scan_mult_i = 4'd5; scan_rng_i = 3'd6;
    @(negedge clk);
    bypass_i = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      scan_mult_i = 4'(k * 7 + 1);
      scan_rng_i  = 3'(k);
      src_sel_i   = k[0];
      @(posedge clk);
      #1 check("R5", 4'd5, 3'd6);
    end

    // R6: reprog pulse with scan select, single cycle, then frozen
    @(negedge clk);
    scan_mult_i = 4'd14; scan_rng_i = 3'd1; src_sel_i = 1'b1; reprog_i = 1'b1;
    @(posedge clk);
    #1 check("R6", 4'd14, 3'd1);
    @(negedge clk);
    reprog_i = 1'b0; scan_mult_i = 4'd2;
    @(posedge clk);
    #1 check("R5", 4'd14, 3'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule